// File: doc/BRIEF.md
# Serial Hex Program Loader

This block fills a processor's program memory from a text hex image that a terminal streams over an asynchronous serial line. It drives the second port of a dual-port program RAM. The processor keeps the first port throughout. While a transfer runs, the loader holds the processor in reset. The loader has its own clock, which may be tied to the processor clock.

Bit timing comes from a phase accumulator. Its carry is a tick at sixteen times the baud rate, and both the receiver and the transmitter step on that tick. A record interpreter turns the colon-led ASCII records into 14-bit word writes. It buffers each record's data until the checksum has been verified. It answers a bad record or an end-of-file record with one character on the transmit line.

Top module: `hex_image_loader`

## Requirements
- R1: While reset is applied and just after it, `cpu_hold_o` is 0, `ser_tx_o` is 1 and `pm_we_o` is 0.
- R2: The phase accumulator adds `INC` on every clock, and its carry is the 16x tick. Transmit frames have one low start bit, eight data bits sent least significant first and one high stop bit, and each bit lasts 16 ticks.
- R3: The receiver samples each bit at its middle. A frame whose stop bit reads low is discarded and never reaches the interpreter.
- R4: A received `:` (0x3A) starts a record and sets `cpu_hold_o` to 1. The output then stays 1 until an end-of-file record with a good checksum arrives. Characters outside a record, such as CR or LF, are ignored.
- R5: A record is a sequence of byte fields, each written as two hex digits with the high nibble first, in either letter case. The fields are the count, the address high byte, the address low byte, the type, then `count` data bytes, then the checksum. The checksum is good when the 8-bit sum of all these bytes is zero.
- R6: A type 0x00 record with a good checksum writes words, one per clock, to consecutive ascending addresses. The first address is the byte address shifted right by one. A data byte at an even position within the record fills bits 7:0 of a word, and the next byte fills bits 13:8 with its two top bits dropped. If the count is odd, the last word has 0 in bits 13:8.
- R7: A record with a bad checksum writes nothing and sends 0x3F.
- R8: A type 0x01 record with a good checksum sets `cpu_hold_o` to 0 and sends 0x2B.
- R9: A record of any other type writes nothing, sends nothing and leaves `cpu_hold_o` unchanged.
- R10: The loader drops a record when its count exceeds `MAX_BYTES` (16), or when a character that is neither a hex digit nor `:` appears inside it. It sends 0x3F, and then ignores all input until the next `:`.
- R11: `pm_we_o` is 1 only while `cpu_hold_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loader clock, also the RAM second-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_rx_i | input | 1 | Serial receive line, idle high |
| ser_tx_o | output | 1 | Serial transmit line, idle high |
| pm_addr_o | output | AW (13) | Word address on the RAM second port |
| pm_data_o | output | 14 | Word written to the RAM second port |
| pm_we_o | output | 1 | Write enable on the RAM second port |
| cpu_hold_o | output | 1 | Processor reset, 1 while a transfer is in progress |

## Verification
The case hardest to reach is a record that is fully parsed but must leave memory untouched. This covers a checksum off by a single bit, a valid record of an unknown type, an oversized count and a stray non-hex letter. The bench produces each of these with a record builder that computes the two's-complement checksum itself and can corrupt it on request. Framing is exercised the same way: the bench's serial driver can send a `:` with a low stop bit before any transfer, and the bench then confirms that `cpu_hold_o` never rises.

// File: rtl/hil_pkg.sv
package hil_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_BODY, PS_CHECK, PS_FLUSH} parse_st_e;
  typedef enum logic [2:0] {RS_IDLE, RS_START, RS_DATA, RS_STOP, RS_WAIT} rx_st_e;

  localparam logic [7:0] COLON = 8'h3A;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39) t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else t = c - 8'h57;
    return t[3:0];
  endfunction
endpackage

// File: rtl/hil_baud.sv
module hil_baud #(
  parameter int ACC_W = 16,
  parameter int INC   = 966
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;

  always_comb begin
    {tick_d, acc_d} = {1'b0, acc_q} + (ACC_W+1)'(INC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  generate
    if (INC < (1 << (ACC_W-1))) begin : g_spaced
      assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/hil_rx.sv
module hil_rx
  import hil_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic       s1_q, line_s;
  rx_st_e     st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       vld_q, vld_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    case (st_q)
      RS_IDLE: if (tick_i && !line_s) begin
        st_d  = RS_START;
        cnt_d = '0;
      end
      RS_START: if (tick_i) begin
        if (cnt_q == 4'd7) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = line_s ? RS_IDLE : RS_DATA;
        end else cnt_d = cnt_q + 4'd1;
      end
      RS_DATA: if (tick_i) begin
        if (cnt_q == 4'd15) begin
          cnt_d = '0;
          sh_d  = {line_s, sh_q[7:1]};
          if (bit_q == 3'd7) st_d = RS_STOP;
          else bit_d = bit_q + 3'd1;
        end else cnt_d = cnt_q + 4'd1;
      end
      RS_STOP: if (tick_i) begin
        if (cnt_q == 4'd15) begin
          if (line_s) begin
            vld_d = 1'b1;
            st_d  = RS_IDLE;
          end else st_d = RS_WAIT;
        end else cnt_d = cnt_q + 4'd1;
      end
      RS_WAIT: if (line_s) st_d = RS_IDLE;
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      line_s <= 1'b1;
      st_q   <= RS_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      s1_q   <= line_i;
      line_s <= s1_q;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_o  = sh_q;
  assign valid_o = vld_q;

  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(line_s));
endmodule

// File: rtl/hil_tx.sv
module hil_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  output logic       line_o
);
  logic       busy_q, busy_d;
  logic [3:0] cnt_q, cnt_d;
  logic [3:0] idx_q, idx_d;
  logic [9:0] sh_q, sh_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, byte_i, 1'b0};
        cnt_d  = '0;
        idx_d  = '0;
      end
    end else if (tick_i) begin
      if (cnt_q == 4'd15) begin
        cnt_d = '0;
        sh_d  = {1'b1, sh_q[9:1]};
        if (idx_q == 4'd9) busy_d = 1'b0;
        else idx_d = idx_q + 4'd1;
      end else cnt_d = cnt_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '1;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assign line_o = busy_q ? sh_q[0] : 1'b1;

  assert_stop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == 4'd9) |-> line_o);
endmodule

// File: rtl/hil_parser.sv
module hil_parser
  import hil_pkg::*;
#(
  parameter int         AW        = 13,
  parameter int         MAX_BYTES = 16,
  parameter logic [7:0] ERR_CHAR  = 8'h3F,
  parameter logic [7:0] ACK_CHAR  = 8'h2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte_i,
  input  logic          rx_valid_i,
  output logic          tx_start_o,
  output logic [7:0]    tx_byte_o,
  output logic [AW-1:0] pm_addr_o,
  output logic [13:0]   pm_data_o,
  output logic          pm_we_o,
  output logic          hold_o
);
  localparam int IX_W = $clog2(MAX_BYTES);
  localparam int MAXW = MAX_BYTES / 2;
  localparam int FL_W = IX_W - 1;

  parse_st_e                 st_q, st_d;
  logic [3:0]                hi_q, hi_d;
  logic                      nib_q, nib_d;
  logic [7:0]                bidx_q, bidx_d;
  logic [7:0]                cnt_q, cnt_d;
  logic [7:0]                ahi_q, ahi_d;
  logic [AW-1:0]             base_q, base_d;
  logic [7:0]                type_q, type_d;
  logic [7:0]                sum_q, sum_d;
  logic [MAXW-1:0][13:0]     buf_q, buf_d;
  logic [FL_W-1:0]           fl_q, fl_d;
  logic                      hold_q, hold_d;
  logic                      txr_q, txr_d;
  logic [7:0]                txb_q, txb_d;

  logic [7:0]      byte_v;
  logic [7:0]      data_k;
  logic [FL_W-1:0] widx;
  logic [7:0]      last_w;

  assign byte_v = {hi_q, hex_val(rx_byte_i)};
  assign data_k = bidx_q - 8'd4;
  assign widx   = data_k[IX_W-1:1];
  assign last_w = ((cnt_q + 8'd1) >> 1) - 8'd1;

  always_comb begin
    st_d   = st_q;
    hi_d   = hi_q;
    nib_d  = nib_q;
    bidx_d = bidx_q;
    cnt_d  = cnt_q;
    ahi_d  = ahi_q;
    base_d = base_q;
    type_d = type_q;
    sum_d  = sum_q;
    buf_d  = buf_q;
    fl_d   = fl_q;
    hold_d = hold_q;
    txr_d  = 1'b0;
    txb_d  = txb_q;
    case (st_q)
      PS_IDLE: if (rx_valid_i && rx_byte_i == COLON) begin
        st_d   = PS_BODY;
        bidx_d = '0;
        sum_d  = '0;
        nib_d  = 1'b0;
        hold_d = 1'b1;
        buf_d  = '0;
      end
      PS_BODY: if (rx_valid_i) begin
        if (rx_byte_i == COLON) begin
          bidx_d = '0;
          sum_d  = '0;
          nib_d  = 1'b0;
          buf_d  = '0;
        end else if (!is_hex(rx_byte_i)) begin
          st_d  = PS_IDLE;
          txr_d = 1'b1;
          txb_d = ERR_CHAR;
        end else if (!nib_q) begin
          hi_d  = hex_val(rx_byte_i);
          nib_d = 1'b1;
        end else begin
          nib_d  = 1'b0;
          sum_d  = sum_q + byte_v;
          bidx_d = bidx_q + 8'd1;
          case (bidx_q)
            8'd0: begin
              cnt_d = byte_v;
              if (byte_v > 8'(MAX_BYTES)) begin
                st_d  = PS_IDLE;
                txr_d = 1'b1;
                txb_d = ERR_CHAR;
              end
            end
            8'd1: ahi_d = byte_v;
            8'd2: base_d = AW'({ahi_q, byte_v} >> 1);
            8'd3: type_d = byte_v;
            default: begin
              if (bidx_q == cnt_q + 8'd4) st_d = PS_CHECK;
              else if (!data_k[0]) buf_d[widx] = {6'd0, byte_v};
              else buf_d[widx][13:8] = byte_v[5:0];
            end
          endcase
        end
      end
      PS_CHECK: begin
        st_d = PS_IDLE;
        fl_d = '0;
        if (sum_q != 8'd0) begin
          txr_d = 1'b1;
          txb_d = ERR_CHAR;
        end else if (type_q == 8'h00) begin
          if (cnt_q != 8'd0) st_d = PS_FLUSH;
        end else if (type_q == 8'h01) begin
          hold_d = 1'b0;
          txr_d  = 1'b1;
          txb_d  = ACK_CHAR;
        end
      end
      PS_FLUSH: begin
        fl_d = fl_q + 1'b1;
        if (8'(fl_q) == last_w) st_d = PS_IDLE;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      hi_q   <= '0;
      nib_q  <= 1'b0;
      bidx_q <= '0;
      cnt_q  <= '0;
      ahi_q  <= '0;
      base_q <= '0;
      type_q <= '0;
      sum_q  <= '0;
      buf_q  <= '0;
      fl_q   <= '0;
      hold_q <= 1'b0;
      txr_q  <= 1'b0;
      txb_q  <= '0;
    end else begin
      st_q   <= st_d;
      hi_q   <= hi_d;
      nib_q  <= nib_d;
      bidx_q <= bidx_d;
      cnt_q  <= cnt_d;
      ahi_q  <= ahi_d;
      base_q <= base_d;
      type_q <= type_d;
      sum_q  <= sum_d;
      buf_q  <= buf_d;
      fl_q   <= fl_d;
      hold_q <= hold_d;
      txr_q  <= txr_d;
      txb_q  <= txb_d;
    end
  end

  assign pm_we_o    = (st_q == PS_FLUSH);
  assign pm_addr_o  = base_q + AW'(fl_q);
  assign pm_data_o  = buf_q[fl_q];
  assign hold_o     = hold_q;
  assign tx_start_o = txr_q;
  assign tx_byte_o  = txb_q;

  assert_write_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we_o |-> hold_o);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_we_o && $past(pm_we_o)) |-> pm_addr_o == $past(pm_addr_o) + AW'(1));
  assert_reply_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> !pm_we_o);
endmodule

// File: rtl/hex_image_loader.sv
module hex_image_loader #(
  parameter int         ACC_W     = 16,
  parameter int         INC       = 966,
  parameter int         AW        = 13,
  parameter int         MAX_BYTES = 16,
  parameter logic [7:0] ERR_CHAR  = 8'h3F,
  parameter logic [7:0] ACK_CHAR  = 8'h2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_rx_i,
  output logic          ser_tx_o,
  output logic [AW-1:0] pm_addr_o,
  output logic [13:0]   pm_data_o,
  output logic          pm_we_o,
  output logic          cpu_hold_o
);
  logic       tick;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       tx_start;
  logic [7:0] tx_byte;

  hil_baud #(.ACC_W(ACC_W), .INC(INC)) u_baud (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  hil_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(ser_rx_i),
    .byte_o(rx_byte), .valid_o(rx_valid));

  hil_parser #(.AW(AW), .MAX_BYTES(MAX_BYTES), .ERR_CHAR(ERR_CHAR),
               .ACK_CHAR(ACK_CHAR)) u_parser (
    .clk(clk), .rst_n(rst_n), .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
    .tx_start_o(tx_start), .tx_byte_o(tx_byte), .pm_addr_o(pm_addr_o),
    .pm_data_o(pm_data_o), .pm_we_o(pm_we_o), .hold_o(cpu_hold_o));

  hil_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(tx_start),
    .byte_i(tx_byte), .line_o(ser_tx_o));
endmodule

// File: tb/test_hex_image_loader.sv
`timescale 1ns/1ps
module test_hex_image_loader;
  localparam int BIT = 64;  // INC = 1/4 of the accumulator range: tick every 4 clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic        tx;
  logic [12:0] pm_addr;
  logic [13:0] pm_data;
  logic        pm_we;
  logic        hold;

  int checks = 0, failures = 0, wr_cnt = 0, tx_cnt = 0;
  logic [7:0]  tx_last = 8'h00;
  logic [13:0] mem [128];
  bit done = 0;

  always #4 clk = ~clk;

  hex_image_loader #(.INC(16384)) i_hex_image_loader (
    .clk(clk), .rst_n(rst_n), .ser_rx_i(rx), .ser_tx_o(tx),
    .pm_addr_o(pm_addr), .pm_data_o(pm_data), .pm_we_o(pm_we), .cpu_hold_o(hold));

  always @(posedge clk) if (rst_n && pm_we) begin
    mem[pm_addr[6:0]] <= pm_data;
    wr_cnt <= wr_cnt + 1;
  end

  initial begin
    wait (rst_n);
    forever begin
      logic [7:0] b;
      @(negedge tx);
      repeat (BIT/2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        b[i] = tx;
      end
      repeat (BIT) @(negedge clk);
      tx_last = b;
      tx_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c, input bit stop_ok);
    @(negedge clk) rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = c[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stop_ok;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n, input bit lower);
    if (n < 10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit lower);
    send_char(hx(b[7:4], lower), 1);
    send_char(hx(b[3:0], lower), 1);
  endtask

  task automatic send_rec(input logic [7:0] cnt, input logic [15:0] addr,
                          input logic [7:0] typ, input logic [31:0] data,
                          input bit lower, input bit corrupt);
    logic [7:0] sum;
    sum = cnt + addr[15:8] + addr[7:0] + typ;
    send_char(8'h3A, 1);
    send_byte(cnt, lower);
    send_byte(addr[15:8], lower);
    send_byte(addr[7:0], lower);
    send_byte(typ, lower);
    for (int i = 0; i < int'(cnt); i++) begin
      logic [7:0] d;
      d = data[8*i +: 8];
      sum += d;
      send_byte(d, lower);
    end
    sum = 8'd0 - sum;
    if (corrupt) sum ^= 8'h01;
    send_byte(sum, lower);
    repeat (800) @(negedge clk);
  endtask

  // {byte address, data bytes (first at [7:0]), word0, word1, lowercase}
  localparam logic [80:0] VEC [4] = '{
    {16'h0010, 32'h3F7F1234, 16'h1234, 16'h3F7F, 1'b0},
    {16'h0020, 32'hFFFF0000, 16'h0000, 16'h3FFF, 1'b0},
    {16'h0004, 32'h4001C5AA, 16'h05AA, 16'h0001, 1'b1},
    {16'h007E, 32'h3CC3A55A, 16'h255A, 16'h3CC3, 1'b0}
  };

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w0, t0, w;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    chk("R1 hold in reset", 32'(hold), 0);
    chk("R1 tx idle in reset", 32'(tx), 1);
    chk("R1 we in reset", 32'(pm_we), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 hold after reset", 32'(hold), 0);

    // R3: colon with a low stop bit must not start a transfer
    send_char(8'h3A, 0);
    repeat (BIT) @(negedge clk);
    chk("R3 framing error ignored", 32'(hold), 0);
    send_char(8'h0D, 1);
    send_char(8'h0A, 1);
    chk("R4 CR LF ignored", 32'(hold), 0);

    foreach (VEC[k]) begin
      w0 = wr_cnt; t0 = tx_cnt;
      send_rec(8'd4, VEC[k][80:65], 8'h00, VEC[k][64:33], VEC[k][0], 0);
      w = int'(VEC[k][80:66]);
      chk("R6 word0", 32'(mem[w[6:0]]), 32'(VEC[k][32:17]));
      chk("R6 word1", 32'(mem[7'(w + 1)]), 32'(VEC[k][16:1]));
      chk("R6 write count", wr_cnt - w0, 2);
      chk("R4 hold during transfer", 32'(hold), 1);
      chk("R5 no reply on good data", tx_cnt - t0, 0);
    end

    // R6 odd count
    w0 = wr_cnt;
    send_rec(8'd3, 16'h0050, 8'h00, 32'h00332211, 0, 0);
    chk("R6 odd count word0", 32'(mem[7'h28]), 32'h2211);
    chk("R6 odd count word1", 32'(mem[7'h29]), 32'h0033);
    chk("R6 odd count writes", wr_cnt - w0, 2);

    // R7 bad checksum
    w0 = wr_cnt; t0 = tx_cnt;
    send_rec(8'd4, 16'h0030, 8'h00, 32'h04030201, 0, 1);
    chk("R7 bad sum no write", wr_cnt - w0, 0);
    chk("R7 bad sum reply count", tx_cnt - t0, 1);
    chk("R7 bad sum reply char", 32'(tx_last), 32'h3F);

    // R9 unknown type
    w0 = wr_cnt; t0 = tx_cnt;
    send_rec(8'd2, 16'h0000, 8'h02, 32'h00003412, 0, 0);
    chk("R9 other type no write", wr_cnt - w0, 0);
    chk("R9 other type no reply", tx_cnt - t0, 0);
    chk("R9 other type hold kept", 32'(hold), 1);

    // R10 oversize count
    w0 = wr_cnt; t0 = tx_cnt;
    send_char(8'h3A, 1); send_byte(8'h20, 0); send_byte(8'h00, 0); send_byte(8'h00, 0);
    repeat (800) @(negedge clk);
    chk("R10 oversize reply", 32'(tx_last), 32'h3F);
    chk("R10 oversize reply count", tx_cnt - t0, 1);

    // R10 non-hex character
    t0 = tx_cnt;
    send_char(8'h3A, 1); send_char(8'h30, 1); send_char(8'h47, 1);
    send_byte(8'h01, 0);
    repeat (800) @(negedge clk);
    chk("R10 non-hex reply", 32'(tx_last), 32'h3F);
    chk("R10 non-hex reply count", tx_cnt - t0, 1);
    chk("R10 no writes", wr_cnt - w0, 0);

    // R8 end of file with bad then good checksum
    send_rec(8'd0, 16'h0000, 8'h01, 32'h0, 0, 1);
    chk("R7 bad eof reply", 32'(tx_last), 32'h3F);
    chk("R4 bad eof keeps hold", 32'(hold), 1);
    t0 = tx_cnt;
    send_rec(8'd0, 16'h0000, 8'h01, 32'h0, 0, 0);
    chk("R8 eof releases hold", 32'(hold), 0);
    chk("R8 eof ack char", 32'(tx_last), 32'h2B);
    chk("R2 one ack frame", tx_cnt - t0, 1);

    // R4 digits outside a record ignored
    w0 = wr_cnt;
    send_byte(8'h12, 0);
    chk("R4 stray digits ignored", 32'(hold), 0);
    chk("R11 no write while released", wr_cnt - w0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule